// File: doc/BRIEF.md
# Asynchronous Static RAM Bus Controller

This block sits between a simple request stream inside the chip and an external asynchronous static RAM of 131,072 words by 16 bits. A requester offers one access at a time (word address, write data, per-byte lane mask and a read/write flag) under a valid/ready handshake. The controller turns each request into a timed sequence on the memory pins: an active-low chip select, write strobe, output strobe and one active-low enable per byte lane. It also drives a split data bus, made of an output-enable, outgoing data and incoming data, that an I/O pad turns into a tri-state bus.

Timing is set by clock-cycle counts rather than nanoseconds. A read holds the output strobe low for a fixed number of wait cycles that covers the memory's address access time, then registers the returned word. A write sets up the address and lanes one cycle before the write strobe falls, holds the strobe low for a set pulse length, and keeps everything stable for one cycle after the strobe rises, because the memory latches data on that rising edge. After every read, the controller keeps the bus quiet with the output strobe high before it can start anything else. This ensures that the memory's drivers are off before the controller's own drivers turn on.

Back-pressure is simple. `req_ready` is high only while the controller is idle. A request transfers on a rising clock edge at which `req_valid` and `req_ready` are both high. The requester must hold its fields stable until that edge and may change them freely afterwards. The response side has no back-pressure: `rsp_valid` is a one-cycle strobe that the requester must take when it comes.

Top module: `sram_bus_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, `sram_dq_oe` is 0, and `sram_ce_n`, `sram_we_n`, `sram_oe_n` and both bits of `sram_be_n` are 1.
- R2: A request is accepted on a clock edge with `req_valid` and `req_ready` both high. `req_ready` stays low from that edge until the access, including any turnaround, has finished. Request fields that change while `req_ready` is low have no effect on the access in progress.
- R3: A read holds `sram_ce_n`=0, `sram_oe_n`=0 and `sram_we_n`=1 for RD_WAIT cycles. Each `sram_be_n` bit is the inverse of the matching `req_lanes` bit: bit 0 is the lane carrying data bits 7:0 and bit 1 is the lane carrying bits 15:8.
- R4: The read word is registered from `sram_dq_in` at the end of the RD_WAIT count. `rsp_valid` is 1 for exactly one cycle, seen RD_WAIT cycles after the accepting edge, with `rsp_rdata` valid in that cycle. Lanes whose `req_lanes` bit is 0 return zero.
- R5: A write runs one setup cycle with `sram_we_n`=1, then WR_PULSE cycles with `sram_we_n`=0, then one hold cycle with `sram_we_n`=1. `sram_ce_n` is 0 and `sram_dq_oe` is 1 throughout. Address, lane enables and `sram_dq_out` stay stable across the rising edge of `sram_we_n`. Only the lanes with their mask bit set are changed in memory.
- R6: `sram_dq_oe` is never 1 while `sram_oe_n` is 0. It only turns on in a cycle that follows a cycle with `sram_oe_n`=1.
- R7: After every read, there are TURN_CYC cycles with every strobe high and `req_ready`=0. The read strobe `rsp_valid` falls in the first of these cycles.
- R8: Whenever `sram_ce_n` is 1, `sram_dq_oe` is 0 and the write strobe, output strobe and lane enables are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_lanes | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_valid | output | 1 | One-cycle read completion strobe |
| rsp_rdata | output | 16 | Read word, disabled lanes zero |
| sram_addr | output | 17 | Memory address |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_oe_n | output | 1 | Output strobe, active low |
| sram_be_n | output | 2 | Lane enables, active low, bit 0 lower byte |
| sram_dq_oe | output | 1 | Enable for the controller's data drivers |
| sram_dq_out | output | 16 | Data the controller drives to the bus |
| sram_dq_in | input | 16 | Data seen on the bus |

## Verification
Two things can happen on adjacent cycles: the end of a read, with the strobe going out and the output strobe rising, and the start of a write that turns the data drivers on. The bench forces this by presenting a write at the very negative edge at which the previous read's turnaround ends, so the write is accepted on the first possible edge. A cycle monitor flags any cycle with drivers on while the output strobe is low. The written and later read-back words are compared against values computed arithmetically in the bench, over every lane mask on a sweep of addresses.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_READ   = 3'd1,
    ST_RTURN  = 3'd2,
    ST_WSETUP = 3'd3,
    ST_WPULSE = 3'd4,
    ST_WHOLD  = 3'd5
  } ctrl_state_t;
endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // R5 / R3: wait counts step down by one each cycle
  a_r3_timer_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/sram_lane_mask.sv
module sram_lane_mask #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic [LANES*LANE_W-1:0] din,
  input  logic [LANES-1:0]        lanes,
  output logic [LANES*LANE_W-1:0] dout
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign dout[g*LANE_W +: LANE_W] = lanes[g] ? din[g*LANE_W +: LANE_W] : '0;
  end
endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int LANES    = 2,
  parameter int LANE_W   = 8,
  parameter int DATA_W   = LANES * LANE_W,
  parameter int RD_WAIT  = 3,
  parameter int WR_PULSE = 2,
  parameter int TURN_CYC = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_lanes,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [LANES-1:0]  sram_be_n,
  output logic              sram_dq_oe,
  output logic [DATA_W-1:0] sram_dq_out,
  input  logic [DATA_W-1:0] sram_dq_in
);
  localparam int MAX_RW = (RD_WAIT > WR_PULSE) ? RD_WAIT : WR_PULSE;
  localparam int MAX_CY = (MAX_RW > TURN_CYC) ? MAX_RW : TURN_CYC;
  localparam int CNT_W  = $clog2(MAX_CY + 1);

  ctrl_state_t       state, nxt_state;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  lanes_q;
  logic              tmr_load, tmr_zero;
  logic [CNT_W-1:0]  tmr_val;
  logic [DATA_W-1:0] rd_masked;
  logic              accept, capture;

  assign accept  = req_valid && (state == ST_IDLE);
  assign capture = (state == ST_READ) && tmr_zero;

  sram_wait_timer #(.CNT_W(CNT_W)) i_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  sram_lane_mask #(.LANES(LANES), .LANE_W(LANE_W)) i_mask (
    .din(sram_dq_in), .lanes(lanes_q), .dout(rd_masked)
  );

  always_comb begin
    nxt_state = state;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    unique case (state)
      ST_IDLE: if (req_valid) begin
        tmr_load = 1'b1;
        if (req_write) begin
          nxt_state = ST_WSETUP;
        end else begin
          nxt_state = ST_READ;
          tmr_val   = CNT_W'(RD_WAIT - 1);
        end
      end
      ST_READ: if (tmr_zero) begin
        nxt_state = ST_RTURN;
        tmr_load  = 1'b1;
        tmr_val   = CNT_W'(TURN_CYC - 1);
      end
      ST_RTURN: if (tmr_zero) nxt_state = ST_IDLE;
      ST_WSETUP: if (tmr_zero) begin
        nxt_state = ST_WPULSE;
        tmr_load  = 1'b1;
        tmr_val   = CNT_W'(WR_PULSE - 1);
      end
      ST_WPULSE: if (tmr_zero) begin
        nxt_state = ST_WHOLD;
        tmr_load  = 1'b1;
      end
      ST_WHOLD: if (tmr_zero) nxt_state = ST_IDLE;
      default: nxt_state = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      lanes_q <= '0;
    end else begin
      state <= nxt_state;
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        lanes_q <= req_lanes;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= capture;
      if (capture) rsp_rdata <= rd_masked;
    end
  end

  logic active, writing;
  assign active  = (state == ST_READ) || writing;
  assign writing = (state == ST_WSETUP) || (state == ST_WPULSE) || (state == ST_WHOLD);

  assign req_ready   = (state == ST_IDLE);
  assign sram_addr   = addr_q;
  assign sram_ce_n   = !active;
  assign sram_oe_n   = (state != ST_READ);
  assign sram_we_n   = (state != ST_WPULSE);
  assign sram_be_n   = active ? ~lanes_q : '1;
  assign sram_dq_oe  = writing;
  assign sram_dq_out = wdata_q;

  // R2: never ready while the memory is selected
  a_r2_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_ce_n |-> !req_ready);
  // R3: output strobe only in a clean read
  a_r3_read_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> (!sram_ce_n && sram_we_n && !sram_dq_oe));
  // R4: response strobe lasts one cycle
  a_r4_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R5: write data latched on a stable bus
  a_r5_we_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> (!sram_ce_n && sram_dq_oe && $stable(sram_addr)
                          && $stable(sram_dq_out) && $stable(sram_be_n)));
  // R6: drivers only after memory outputs are off
  a_r6_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_dq_oe) |-> ($past(sram_oe_n) && sram_oe_n));
  // R7: strobe falls into a quiet turnaround cycle
  a_r7_turn: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (sram_ce_n && sram_oe_n && !req_ready));
  // R8: standby keeps everything released
  a_r8_standby: assert property (@(posedge clk) disable iff (!rst_n)
    sram_ce_n |-> (!sram_dq_oe && sram_we_n && sram_oe_n && (&sram_be_n)));
endmodule

// File: tb/test_sram_bus_ctrl.sv
module test_sram_bus_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int RD_WAIT = 3;
  localparam int WR_PULSE = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_lanes = '0;
  logic req_ready, rsp_valid, sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe;
  logic [15:0] rsp_rdata, sram_dq_out, sram_dq_in;
  logic [16:0] sram_addr;
  logic [1:0]  sram_be_n;

  int compared = 0, mismatched = 0, cyc = 0, contention = 0, bad_drive = 0;
  logic [15:0] mem [0:63];
  logic [15:0] exp_mem [0:63];

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_bus_ctrl i_sram_bus_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_lanes(req_lanes), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
    .sram_oe_n(sram_oe_n), .sram_be_n(sram_be_n), .sram_dq_oe(sram_dq_oe),
    .sram_dq_out(sram_dq_out), .sram_dq_in(sram_dq_in)
  );

  // memory model: disabled lanes and idle bus read as junk
  always_comb begin
    if (!sram_ce_n && !sram_oe_n && sram_we_n)
      sram_dq_in = {sram_be_n[1] ? 8'hA5 : mem[sram_addr[5:0]][15:8],
                    sram_be_n[0] ? 8'h5A : mem[sram_addr[5:0]][7:0]};
    else
      sram_dq_in = 16'hBEEF;
  end

  always @(posedge sram_we_n) begin
    if (rst_n && !sram_ce_n) begin
      if (!sram_dq_oe) bad_drive++;
      if (!sram_be_n[0]) mem[sram_addr[5:0]][7:0]  = sram_dq_out[7:0];
      if (!sram_be_n[1]) mem[sram_addr[5:0]][15:8] = sram_dq_out[15:8];
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (sram_dq_oe && !sram_oe_n) contention++;
    if (cyc > 100000) begin
      mismatched++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 100000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic wr, input logic [16:0] a, input logic [15:0] d,
                       input logic [1:0] m);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_lanes = m;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    // R2: scramble fields after acceptance
    req_addr = ~a; req_wdata = ~d; req_lanes = ~m; req_write = ~wr;
  endtask

  task automatic do_write(input logic [16:0] a, input logic [15:0] d, input logic [1:0] m);
    issue(1'b1, a, d, m);
    check("R5 setup", {sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe, req_ready, 2'b0, sram_be_n},
          {1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'b0, ~m});
    for (int k = 0; k < WR_PULSE; k++) begin
      @(negedge clk);
      check("R5 pulse", {sram_we_n, sram_dq_oe, sram_dq_out}, {1'b0, 1'b1, d});
    end
    @(negedge clk);
    check("R5 hold", {sram_we_n, sram_ce_n, sram_dq_oe, sram_addr}, {1'b1, 1'b0, 1'b1, a});
    @(negedge clk);
    check("R8 idle after write", {req_ready, sram_ce_n, sram_dq_oe}, 3'b110);
    if (m[0]) exp_mem[a[5:0]][7:0]  = d[7:0];
    if (m[1]) exp_mem[a[5:0]][15:8] = d[15:8];
  endtask

  task automatic do_read(input logic [16:0] a, input logic [1:0] m);
    int k;
    logic [15:0] e;
    issue(1'b0, a, 16'h0, m);
    check("R3 strobes", {sram_ce_n, sram_oe_n, sram_we_n, sram_be_n}, {3'b001, ~m});
    k = 0;
    while (!rsp_valid && k < 20) begin
      @(negedge clk);
      k++;
    end
    check("R4 latency", k, RD_WAIT);
    e = {m[1] ? exp_mem[a[5:0]][15:8] : 8'h00, m[0] ? exp_mem[a[5:0]][7:0] : 8'h00};
    check("R4 data", rsp_rdata, e);
    check("R7 turnaround", {req_ready, sram_oe_n, sram_ce_n, sram_dq_oe}, 4'b0110);
    @(negedge clk);
    check("R4 single pulse", {rsp_valid, req_ready}, 2'b01);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      mem[i] = 16'hC3C3;
      exp_mem[i] = 16'hC3C3;
    end
    repeat (3) @(negedge clk);
    check("R1 reset", {req_ready, rsp_valid, sram_dq_oe, sram_ce_n, sram_we_n, sram_oe_n, sram_be_n},
          8'b10011111);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", {req_ready, rsp_valid, sram_dq_oe, sram_ce_n}, 4'b1001);
    // writes over a sweep with every lane mask
    for (int a = 0; a < 32; a++)
      do_write(17'(a), 16'(a * 16'h0123) ^ 16'hA55A, 2'(a % 4));
    // read back every lane mask
    for (int a = 0; a < 32; a++)
      for (int m = 0; m < 4; m++)
        do_read(17'(a), 2'(m));
    // read immediately followed by write, then verify (R6 turnaround)
    for (int a = 32; a < 48; a++) begin
      do_read(17'(a), 2'b11);
      do_write(17'(a), 16'(a * 16'h0F1D), 2'b11);
      do_read(17'(a), 2'b11);
    end
    check("R6 contention cycles", contention, 0);
    check("R5 write edge without drivers", bad_drive, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule